// File: doc/BRIEF.md
# Memory and I/O Chip-Select Decoder

This block sits beside a processor's 20-bit address bus and decides which device, if any, answers the current bus cycle. A space qualifier chooses between the memory space and a separate 64 KB port space. The active-low read and write strobes gate every select. In the memory space there are three targets: a 32 KB RAM at the bottom of memory, an 8 KB boot ROM at the top (this region holds the reset fetch address), and a 16-byte memory-mapped peripheral window. In the port space there are two targets: a keyboard port and a serial data port.

When a strobed access matches no device, the block raises a no-device flag. When a write lands in the ROM region, the block raises a ROM-write error flag and keeps the ROM deselected. The outputs can be taken straight from the decode logic or from a register stage, chosen by a parameter. The default is the registered stage, which gives one clock of latency and resets to all-inactive.

There is no state machine. The only sequential element is the optional output register.

Top module: `mem_io_decoder`

## Requirements
- R1: With mem_io = 1 and a strobe active, ram_cs_n is 0 exactly when address bits 19..15 are all zero (00000h to 07FFFh).
- R2: With mem_io = 1 and a read strobe active (wr_n = 1), rom_cs_n is 0 exactly when address bits 19..13 are all one (FE000h to FFFFFh). This range includes FFFF0h.
- R3: With mem_io = 1 and a strobe active, mmio_cs_n is 0 exactly for addresses A0000h to A000Fh. A0010h does not select it.
- R4: With mem_io = 0 and a strobe active, only address bits 15..0 are decoded. Port 0060h drives kbd_cs_n to 0 and port 03F8h drives ser_cs_n to 0, whatever bits 19..16 hold.
- R5: A memory access never asserts a port select, and a port access never asserts a memory select. At most one select is low at any time.
- R6: When rd_n = 1 and wr_n = 1, all selects are 1 and both flags are 0.
- R7: A strobed access that matches no region sets no_dev = 1 and leaves every select at 1.
- R8: A write (wr_n = 0, including when rd_n is also 0) to the ROM region sets rom_wr_err = 1, keeps rom_cs_n = 1 and keeps no_dev = 0.
- R9: With REG_OUT = 1, outputs follow the inputs one rising clock edge later. While rst_n = 0, all selects read 1 and both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| addr | input | 20 | Address bus |
| mem_io | input | 1 | Space qualifier: 1 selects memory, 0 selects ports |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| mmio_cs_n | output | 1 | Memory-mapped peripheral select, active low |
| kbd_cs_n | output | 1 | Keyboard port select, active low |
| ser_cs_n | output | 1 | Serial data port select, active low |
| no_dev | output | 1 | Access matched no device |
| rom_wr_err | output | 1 | Write attempted into the ROM region |

## Verification
The bench probes the edges of each region:
- 07FFFh against 08000h. A design that compares one address bit too many or too few would put RAM over a hole.
- FE000h against FDFFFh. The same kind of error would shift the ROM boundary.
- A000Fh against A0010h. A window that is too wide would answer at A0010h.

It also drives port numbers through the memory space and the reverse, and drives port addresses with junk in bits 19..16. A decoder that ignored the space qualifier would fire two selects at once, and one that decoded all 20 bits in port space would miss the keyboard. Finally, it writes and read-writes into the ROM. A design that forgot to suppress the select would let a write reach the ROM, and one that mis-ordered the flags would report an error access as unmapped.

// File: rtl/mem_io_decoder_pkg.sv
package mem_io_decoder_pkg;

    // Active-high internal view of one decode result.
    typedef struct packed {
        logic ram;
        logic rom;
        logic mmio;
        logic kbd;
        logic ser;
        logic no_dev;
        logic rom_wr_err;
    } dec_t;

    localparam dec_t DEC_IDLE = '0;

endpackage

// File: rtl/region_match.sv
module region_match #(
    parameter int              ADDR_W    = 20,
    parameter int              SIZE_LOG2 = 15,
    parameter logic [ADDR_W-1:0] BASE    = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << SIZE_LOG2) - 64'd1);
    localparam logic [ADDR_W-1:0] HI_MASK  = ~LOW_ONES;

    always_comb begin
        hit = (((addr ^ BASE) & HI_MASK) == '0);
    end
endmodule

// File: rtl/decode_core.sv
module decode_core
    import mem_io_decoder_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              IO_W       = 16,
    parameter int              RAM_LOG2   = 15,
    parameter int              ROM_LOG2   = 13,
    parameter logic [ADDR_W-1:0] MMIO_BASE = 20'hA0000,
    parameter int              MMIO_LOG2  = 4,
    parameter logic [IO_W-1:0] KBD_PORT   = 16'h0060,
    parameter logic [IO_W-1:0] SER_PORT   = 16'h03F8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_io,
    input  logic              rd_n,
    input  logic              wr_n,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] RAM_BASE = '0;
    localparam logic [ADDR_W-1:0] ROM_BASE = {ADDR_W{1'b1}} << ROM_LOG2;
    localparam int NUM_MEM = 3;
    localparam int NUM_IO  = 2;

    localparam int                  MEM_LOG2 [NUM_MEM] = '{RAM_LOG2, ROM_LOG2, MMIO_LOG2};
    localparam logic [ADDR_W-1:0]   MEM_BASE [NUM_MEM] = '{RAM_BASE, ROM_BASE, MMIO_BASE};
    localparam logic [IO_W-1:0]     IO_PORT  [NUM_IO]  = '{KBD_PORT, SER_PORT};

    logic [NUM_MEM-1:0] mem_hit;
    logic [NUM_IO-1:0]  io_hit;

    generate
        for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
            region_match #(
                .ADDR_W   (ADDR_W),
                .SIZE_LOG2(MEM_LOG2[g]),
                .BASE     (MEM_BASE[g])
            ) u_match (
                .addr(addr),
                .hit (mem_hit[g])
            );
        end
        for (genvar p = 0; p < NUM_IO; p++) begin : g_io
            region_match #(
                .ADDR_W   (IO_W),
                .SIZE_LOG2(0),
                .BASE     (IO_PORT[p])
            ) u_port (
                .addr(addr[IO_W-1:0]),
                .hit (io_hit[p])
            );
        end
    endgenerate

    logic strobe;
    logic is_wr;
    logic any_hit;

    always_comb begin
        strobe  = !rd_n || !wr_n;
        is_wr   = !wr_n;
        dec     = DEC_IDLE;
        any_hit = 1'b0;
        if (strobe) begin
            if (mem_io) begin
                any_hit = |mem_hit;
                dec.ram = mem_hit[0];
                dec.mmio = mem_hit[2];
                if (mem_hit[1]) begin
                    if (is_wr) begin
                        dec.rom_wr_err = 1'b1;
                    end else begin
                        dec.rom = 1'b1;
                    end
                end
            end else begin
                any_hit = |io_hit;
                dec.kbd = io_hit[0];
                dec.ser = io_hit[1];
            end
            dec.no_dev = !any_hit;
        end
    end
endmodule

// File: rtl/dec_stage.sv
module dec_stage
    import mem_io_decoder_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  dec_t d,
    output dec_t q
);
    generate
        if (REG_OUT) begin : g_reg
            dec_t q_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_r <= DEC_IDLE;
                end else begin
                    q_r <= d;
                end
            end
            assign q = q_r;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst_n;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/mem_io_decoder.sv
module mem_io_decoder
    import mem_io_decoder_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              IO_W       = 16,
    parameter int              RAM_LOG2   = 15,
    parameter int              ROM_LOG2   = 13,
    parameter logic [ADDR_W-1:0] MMIO_BASE = 20'hA0000,
    parameter int              MMIO_LOG2  = 4,
    parameter logic [IO_W-1:0] KBD_PORT   = 16'h0060,
    parameter logic [IO_W-1:0] SER_PORT   = 16'h03F8,
    parameter bit              REG_OUT    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_io,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic              ram_cs_n,
    output logic              rom_cs_n,
    output logic              mmio_cs_n,
    output logic              kbd_cs_n,
    output logic              ser_cs_n,
    output logic              no_dev,
    output logic              rom_wr_err
);
    dec_t dec_raw;
    dec_t dec_out;

    decode_core #(
        .ADDR_W   (ADDR_W),
        .IO_W     (IO_W),
        .RAM_LOG2 (RAM_LOG2),
        .ROM_LOG2 (ROM_LOG2),
        .MMIO_BASE(MMIO_BASE),
        .MMIO_LOG2(MMIO_LOG2),
        .KBD_PORT (KBD_PORT),
        .SER_PORT (SER_PORT)
    ) u_core (
        .addr  (addr),
        .mem_io(mem_io),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .dec   (dec_raw)
    );

    dec_stage #(
        .REG_OUT(REG_OUT)
    ) u_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (dec_raw),
        .q    (dec_out)
    );

    always_comb begin
        ram_cs_n   = !dec_out.ram;
        rom_cs_n   = !dec_out.rom;
        mmio_cs_n  = !dec_out.mmio;
        kbd_cs_n   = !dec_out.kbd;
        ser_cs_n   = !dec_out.ser;
        no_dev     = dec_out.no_dev;
        rom_wr_err = dec_out.rom_wr_err;
    end
endmodule

// File: rtl/mem_io_decoder_chk.sv
module mem_io_decoder_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [19:0] addr,
    input logic        mem_io,
    input logic        rd_n,
    input logic        wr_n,
    input logic        ram_cs_n,
    input logic        rom_cs_n,
    input logic        mmio_cs_n,
    input logic        kbd_cs_n,
    input logic        ser_cs_n,
    input logic        no_dev,
    input logic        rom_wr_err
);
    logic [4:0] sel;
    logic       unused_in;
    assign sel       = ~{ram_cs_n, rom_cs_n, mmio_cs_n, kbd_cs_n, ser_cs_n};
    assign unused_in = ^{addr, mem_io};

    // R5: never two selects at once
    p_one_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R7: unmapped access leaves every select inactive
    p_nodev_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        no_dev |-> (sel == 5'b0));

    // R8: ROM-write error keeps ROM deselected and is not unmapped
    p_romerr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr_err |-> (rom_cs_n && !no_dev));

    // R9: reset state is all inactive
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |-> (sel == 5'b0 && !no_dev && !rom_wr_err));

    generate
        if (REG_OUT) begin : g_reg
            // R6: idle bus yields quiet outputs one edge later
            p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_n && wr_n) |=> (sel == 5'b0 && !no_dev && !rom_wr_err));
        end else begin : g_comb
            // R6: idle bus yields quiet outputs
            p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_n && wr_n) |-> (sel == 5'b0 && !no_dev && !rom_wr_err));
        end
    endgenerate
endmodule

bind mem_io_decoder mem_io_decoder_chk #(.REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/mem_io_decoder_tb_top.sv
module mem_io_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        mem_io = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        ram_cs_n, rom_cs_n, mmio_cs_n, kbd_cs_n, ser_cs_n, no_dev, rom_wr_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #10 clk = ~clk;

    mem_io_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_io(mem_io),
        .rd_n(rd_n), .wr_n(wr_n),
        .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .mmio_cs_n(mmio_cs_n),
        .kbd_cs_n(kbd_cs_n), .ser_cs_n(ser_cs_n),
        .no_dev(no_dev), .rom_wr_err(rom_wr_err)
    );

    // Bit order {ram, rom, mmio, kbd, ser, no_dev, rom_wr_err}, active high.
    function automatic logic [6:0] model(input logic [19:0] a, input logic mio,
                                         input logic r_n, input logic w_n);
        logic ram, rom, mm, kb, se, nd, er, romreg;
        ram = 0; rom = 0; mm = 0; kb = 0; se = 0; nd = 0; er = 0;
        if (!r_n || !w_n) begin
            if (mio) begin
                ram    = (a[19:15] == 5'h00);
                romreg = (a[19:13] == 7'h7F);
                mm     = (a[19:4] == 16'hA000);
                if (romreg && !w_n) er = 1;
                else rom = romreg;
                nd = !(ram || romreg || mm);
            end else begin
                kb = (a[15:0] == 16'h0060);
                se = (a[15:0] == 16'h03F8);
                nd = !(kb || se);
            end
        end
        return {ram, rom, mm, kb, se, nd, er};
    endfunction

    function automatic logic [6:0] observed();
        return {!ram_cs_n, !rom_cs_n, !mmio_cs_n, !kbd_cs_n, !ser_cs_n, no_dev, rom_wr_err};
    endfunction

    task automatic check(input logic [6:0] got, input logic [6:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [19:0] a, input logic mio,
                         input logic r_n, input logic w_n, input string tag);
        item_t it;
        @(negedge clk);
        addr = a; mem_io = mio; rd_n = r_n; wr_n = w_n;
        it.exp = model(a, mio, r_n, w_n);
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: outputs settle one edge after the driver's negedge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                check(observed(), it.exp, it.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(observed(), 7'b0, "R9 reset idle");
        @(negedge clk);
        rst_n = 1'b1;

        drive(20'h00000, 1, 0, 1, "R1 ram low edge");
        drive(20'h07FFF, 1, 0, 1, "R1 ram high edge");
        drive(20'h04000, 1, 1, 0, "R1 ram write");
        drive(20'h08000, 1, 0, 1, "R7 above ram");
        drive(20'hFFFF0, 1, 0, 1, "R2 rom reset fetch");
        drive(20'hFE000, 1, 0, 1, "R2 rom low edge");
        drive(20'hFDFFF, 1, 0, 1, "R7 below rom");
        drive(20'hFFFF0, 1, 1, 0, "R8 rom write");
        drive(20'hFE004, 1, 0, 0, "R8 rom read+write");
        drive(20'hA0000, 1, 0, 1, "R3 mmio base");
        drive(20'hA000F, 1, 1, 0, "R3 mmio top");
        drive(20'hA0010, 1, 0, 1, "R3 R7 past mmio");
        drive(20'h00060, 0, 0, 1, "R4 kbd port");
        drive(20'h003F8, 0, 1, 0, "R4 serial port");
        drive(20'hF0060, 0, 0, 1, "R4 upper bits ignored");
        drive(20'h00061, 0, 0, 1, "R7 unused port");
        drive(20'h00060, 1, 0, 1, "R5 port number in memory");
        drive(20'hA0000, 0, 0, 1, "R5 mmio address in port space");
        drive(20'h003F8, 1, 1, 0, "R5 serial number in memory");
        drive(20'hFFFF0, 1, 1, 1, "R6 no strobe rom");
        drive(20'h00060, 0, 1, 1, "R6 no strobe port");
        drive(20'h00010, 1, 0, 0, "R1 both strobes ram");
        drive(20'h00000, 1, 1, 1, "R6 idle");

        // R9: a new access is not visible before the next rising edge
        @(negedge clk);
        addr = 20'h003F8; mem_io = 0; rd_n = 0; wr_n = 1;
        #2;
        check(observed(), 7'b0, "R9 latency before edge");
        begin
            item_t it;
            it.exp = model(20'h003F8, 0, 0, 1);
            it.tag = "R9 latency after edge";
            exp_q.push_back(it);
        end

        // R9: asynchronous reset returns outputs to idle
        @(posedge clk);
        #7;
        rst_n = 1'b0;
        #1;
        check(observed(), 7'b0, "R9 async reset");
        exp_q.delete();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule